// File: doc/BRIEF.md
# Masked Memory Checksum Calculator

This block walks a memory image of 14-bit words and folds it into a 16-bit checksum. It drives a simple read port: one address per cycle, with the word returned one cycle later. It reads the two configuration words first. The protect flag in the first configuration word then picks one of two paths. If protection is off, the block reads the whole program region from address 0 up to a last address set by a size parameter. If protection is on, it skips program memory and reads only the four user ID words.

Both configuration words are masked before they are added, and all additions wrap at 16 bits. On the protected path, the low nibble of each user ID is placed into its own nibble of a 16-bit value. That value is added in place of the program words. A start pulse begins a pass. A one-cycle done pulse marks the point where the checksum output is final. The checksum holds until the next accepted start.

Top module: `mem_checksum`

## Requirements
- R1: After reset, done and rd_en are low and checksum is 0.
- R2: An accepted start makes the block read the first configuration word at 0x8007, then the second at 0x8008, on consecutive cycles. It then reads the program words (from 0) or the user IDs (from 0x8000), one read per cycle, and takes each word on rd_data in the cycle after its read.
- R3: The running sum is 16 bits wide, and any carry out of bit 15 is dropped.
- R4: When protection is off, every program word from address 0 through PROG_LAST is added exactly once, in rising address order. The default PROG_LAST is 0xFFF, and the large size uses 0x1FFF.
- R5: The first configuration word is ANDed with 0x3EFF and the second with 0x3F87 before each is added.
- R6: Protection is on exactly when bit 7 of the first configuration word is 0.
- R7: When protection is on, no address below 0x8000 is read. The four user IDs at 0x8000 to 0x8003 add the value {id0[3:0], id1[3:0], id2[3:0], id3[3:0]}, so the ID at 0x8000 gives the top nibble. The upper ID bits have no effect.
- R8: done is high for exactly one cycle, two cycles after the last read. From that cycle on, checksum holds its value until the next accepted start.
- R9: A start pulse that arrives while a pass is running is ignored. The pass keeps its read sequence, its timing and its result.
- R10: A blank image, with every word 0x3FFF including both configuration words, gives 0x6E86 with PROG_LAST = 0xFFF and 0x5E86 with PROG_LAST = 0x1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a pass; accepted only when idle |
| rd_en | output | 1 | Read strobe toward the memory image |
| rd_addr | output | 16 | Word address of the read |
| rd_data | input | 14 | Word returned one cycle after rd_en |
| done | output | 1 | One-cycle pulse: checksum is final |
| checksum | output | 16 | Accumulated 16-bit checksum |

## Verification
The bench sweeps the protected path over many user ID patterns whose upper bits are set. A design that used the wrong nibble order, or let the upper ID bits through, would give the wrong sum. It also checks that no program address is read on that path, so a design that reads program memory anyway is caught.

Configuration words are chosen with bits set outside each mask. A design that swapped or dropped a mask would show up in the sum. The blank images overflow many times, so a sum wider than 16 bits or a missed final word would show as a wrong constant.

The bench measures the latency to done and the read count of every pass, so a read issued too early or too late is caught. A start pulse injected mid-pass exposes a design that restarts or clears its sum while busy.

// File: rtl/mem_checksum_pkg.sv
package mem_checksum_pkg;

   // Source of the word that returns on the read port
   typedef enum logic [1:0] {
      SRC_CFG_A = 2'd0,
      SRC_CFG_B = 2'd1,
      SRC_PROG  = 2'd2,
      SRC_UID   = 2'd3
   } src_e;

   // Sequencer phases
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_CFG_A = 3'd1,
      PH_CFG_B = 3'd2,
      PH_PROG  = 3'd3,
      PH_UID   = 3'd4,
      PH_DRAIN = 3'd5
   } phase_e;

endpackage

// File: rtl/mem_checksum_seq.sv
module mem_checksum_seq
   import mem_checksum_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PROG_LAST = 'hFFF,
   parameter int unsigned CFG_A_ADR = 'h8007,
   parameter int unsigned CFG_B_ADR = 'h8008,
   parameter int unsigned UID_BASE  = 'h8000,
   parameter int unsigned UID_COUNT = 4,
   localparam int unsigned IDX_W    = $clog2(UID_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              prot_off,   // protect flag of first config word, valid in PH_CFG_B
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output src_e              iss_src,
   output logic [IDX_W-1:0]  iss_idx,
   output logic              iss_last,
   output logic              busy,
   output logic              clear
);

   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(PROG_LAST);
   localparam logic [ADDR_W-1:0] CFGA_A  = ADDR_W'(CFG_A_ADR);
   localparam logic [ADDR_W-1:0] CFGB_A  = ADDR_W'(CFG_B_ADR);
   localparam logic [ADDR_W-1:0] UID_A   = ADDR_W'(UID_BASE);
   localparam logic [ADDR_W-1:0] UID_END = ADDR_W'(UID_COUNT - 1);

   phase_e            phase_q, phase_d;
   logic [ADDR_W-1:0] cnt_q, cnt_d;

   always_comb begin
      phase_d  = phase_q;
      cnt_d    = cnt_q;
      rd_en    = 1'b0;
      rd_addr  = '0;
      iss_src  = SRC_PROG;
      iss_idx  = '0;
      iss_last = 1'b0;
      clear    = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               clear   = 1'b1;
               phase_d = PH_CFG_A;
            end
         end
         PH_CFG_A: begin
            rd_en   = 1'b1;
            rd_addr = CFGA_A;
            iss_src = SRC_CFG_A;
            phase_d = PH_CFG_B;
         end
         PH_CFG_B: begin
            rd_en   = 1'b1;
            rd_addr = CFGB_A;
            iss_src = SRC_CFG_B;
            cnt_d   = '0;
            phase_d = prot_off ? PH_PROG : PH_UID;
         end
         PH_PROG: begin
            rd_en    = 1'b1;
            rd_addr  = cnt_q;
            iss_src  = SRC_PROG;
            iss_last = (cnt_q == LAST_A);
            if (iss_last) phase_d = PH_DRAIN;
            else          cnt_d   = cnt_q + ADDR_W'(1);
         end
         PH_UID: begin
            rd_en    = 1'b1;
            rd_addr  = UID_A + cnt_q;
            iss_src  = SRC_UID;
            iss_idx  = cnt_q[IDX_W-1:0];
            iss_last = (cnt_q == UID_END);
            if (iss_last) phase_d = PH_DRAIN;
            else          cnt_d   = cnt_q + ADDR_W'(1);
         end
         PH_DRAIN: phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   assign busy = (phase_q != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   // R2: an accepted start leads straight to the first configuration read
   assert_cfg_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (rd_en && rd_addr == CFGA_A));

   // R4: program reads step by one address per cycle
   assert_prog_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && iss_src == SRC_PROG && $past(rd_en) && $past(iss_src) == SRC_PROG)
      |-> rd_addr == $past(rd_addr) + ADDR_W'(1));

   // R7: protected reads stay inside the user ID window
   assert_uid_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && iss_src == SRC_UID) |-> (rd_addr >= UID_A && rd_addr <= UID_A + UID_END));

   // R9: a start during a pass does not end the pass
   assert_busy_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && phase_q != PH_DRAIN) |=> busy);

endmodule

// File: rtl/mem_checksum_cond.sv
module mem_checksum_cond
   import mem_checksum_pkg::*;
#(
   parameter int unsigned DATA_W     = 14,
   parameter int unsigned SUM_W      = 16,
   parameter int unsigned NIB_W      = 4,
   parameter int unsigned UID_COUNT  = 4,
   parameter logic [DATA_W-1:0] KEEP_A = 14'h3EFF,
   parameter logic [DATA_W-1:0] KEEP_B = 14'h3F87,
   localparam int unsigned IDX_W     = $clog2(UID_COUNT)
) (
   input  src_e              src,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] word,
   output logic [SUM_W-1:0]  addend
);

   logic [SUM_W-1:0] nib_tbl [UID_COUNT];

   // Each user ID owns one nibble slot; the first ID sits highest
   for (genvar k = 0; k < UID_COUNT; k++) begin : g_slot
      assign nib_tbl[k] = SUM_W'(word[NIB_W-1:0]) << (NIB_W * (UID_COUNT - 1 - k));
   end

   always_comb begin
      unique case (src)
         SRC_CFG_A: addend = SUM_W'(word & KEEP_A);
         SRC_CFG_B: addend = SUM_W'(word & KEEP_B);
         SRC_UID:   addend = nib_tbl[idx];
         default:   addend = SUM_W'(word);
      endcase
   end

endmodule

// File: rtl/mem_checksum_acc.sv
module mem_checksum_acc #(
   parameter int unsigned SUM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             add_en,
   input  logic             add_last,
   input  logic [SUM_W-1:0] addend,
   output logic [SUM_W-1:0] sum,
   output logic             done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum  <= '0;
         done <= 1'b0;
      end else begin
         done <= add_en && add_last;
         if (clear)       sum <= '0;
         else if (add_en) sum <= sum + addend;   // carry out of the top bit drops
      end
   end

   // R8: done lasts a single cycle
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: sum stays put while nothing is added or cleared
   assert_sum_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done) && !clear && !add_en) |=> $stable(sum));

endmodule

// File: rtl/mem_checksum.sv
module mem_checksum
   import mem_checksum_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 14,
   parameter int unsigned SUM_W     = 16,
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned PROG_LAST = 'hFFF,
   parameter int unsigned CFG_A_ADR = 'h8007,
   parameter int unsigned CFG_B_ADR = 'h8008,
   parameter int unsigned UID_BASE  = 'h8000,
   parameter int unsigned UID_COUNT = 4,
   parameter int unsigned PROT_BIT  = 7,
   parameter logic [DATA_W-1:0] KEEP_A = 14'h3EFF,
   parameter logic [DATA_W-1:0] KEEP_B = 14'h3F87
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic [SUM_W-1:0]  checksum
);

   localparam int unsigned IDX_W = $clog2(UID_COUNT);

   // Elaboration-time parameter checks
   if (SUM_W < DATA_W) begin : g_bad_sum
      $error("checksum width must cover a data word");
   end
   if (NIB_W * UID_COUNT > SUM_W) begin : g_bad_nib
      $error("user ID nibbles do not fit the checksum width");
   end
   if (UID_COUNT < 2) begin : g_bad_uid
      $error("at least two user ID words are required");
   end
   if (PROG_LAST >= UID_BASE || PROT_BIT >= DATA_W) begin : g_bad_map
      $error("program region must lie below the configuration region");
   end

   src_e             iss_src, src_q;
   logic [IDX_W-1:0] iss_idx, idx_q;
   logic             iss_last, last_q, vld_q;
   logic             busy, clear;
   logic [SUM_W-1:0] addend;

   mem_checksum_seq #(
      .ADDR_W   (ADDR_W),
      .PROG_LAST(PROG_LAST),
      .CFG_A_ADR(CFG_A_ADR),
      .CFG_B_ADR(CFG_B_ADR),
      .UID_BASE (UID_BASE),
      .UID_COUNT(UID_COUNT)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .prot_off(rd_data[PROT_BIT]),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .iss_src (iss_src),
      .iss_idx (iss_idx),
      .iss_last(iss_last),
      .busy    (busy),
      .clear   (clear)
   );

   // Tag of the read in flight, aligned with rd_data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         src_q  <= SRC_PROG;
         idx_q  <= '0;
         last_q <= 1'b0;
      end else begin
         vld_q  <= rd_en;
         src_q  <= iss_src;
         idx_q  <= iss_idx;
         last_q <= iss_last;
      end
   end

   mem_checksum_cond #(
      .DATA_W   (DATA_W),
      .SUM_W    (SUM_W),
      .NIB_W    (NIB_W),
      .UID_COUNT(UID_COUNT),
      .KEEP_A   (KEEP_A),
      .KEEP_B   (KEEP_B)
   ) u_cond (
      .src   (src_q),
      .idx   (idx_q),
      .word  (rd_data),
      .addend(addend)
   );

   mem_checksum_acc #(
      .SUM_W(SUM_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .add_en  (vld_q),
      .add_last(last_q),
      .addend  (addend),
      .sum     (checksum),
      .done    (done)
   );

   // R8: done arrives two cycles after the final read
   assert_done_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(vld_q) && $past(last_q) && !rd_en));

   // R2: a word is consumed only in the cycle after its read
   assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> $past(rd_en));

   // R1: no read strobe outside a pass
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_en);

endmodule

// File: tb/mem_checksum_bench.sv
module mem_checksum_bench;

   localparam int CLK_PERIOD = 10;
   localparam int SMALL_LAST = 'hFFF;
   localparam int BIG_LAST   = 'h1FFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        start_a = 1'b0, start_b = 1'b0;
   logic        rd_en_a, rd_en_b, done_a, done_b;
   logic [15:0] rd_addr_a, rd_addr_b, sum_a, sum_b;
   logic [13:0] rd_data_a, rd_data_b;

   mem_checksum u_mem_checksum (
      .clk(clk), .rst_n(rst_n), .start(start_a), .rd_en(rd_en_a),
      .rd_addr(rd_addr_a), .rd_data(rd_data_a), .done(done_a), .checksum(sum_a));

   mem_checksum #(.PROG_LAST(BIG_LAST)) u_mem_checksum_big (
      .clk(clk), .rst_n(rst_n), .start(start_b), .rd_en(rd_en_b),
      .rd_addr(rd_addr_b), .rd_data(rd_data_b), .done(done_b), .checksum(sum_b));

   // Image contents
   int          mode = 0;
   logic [13:0] cfg_a = 14'h3FFF, cfg_b = 14'h3FFF;
   logic [13:0] uid [4];

   function automatic logic [13:0] mem_word(input logic [15:0] a);
      if (a < 16'h8000) begin
         case (mode)
            0:       return 14'h3FFF;
            1:       return 14'(a * 16'd37 + 16'd11);
            default: return 14'(a ^ {a[7:0], a[15:8]});
         endcase
      end
      if (a == 16'h8007) return cfg_a;
      if (a == 16'h8008) return cfg_b;
      if (a >= 16'h8000 && a <= 16'h8003) return uid[a[1:0]];
      return 14'h3FFF;
   endfunction

   always @(posedge clk) begin
      if (rd_en_a) rd_data_a <= mem_word(rd_addr_a);
      if (rd_en_b) rd_data_b <= mem_word(rd_addr_b);
   end

   // Selected instance view
   bit          sel_big = 1'b0;
   logic        cur_rd_en, cur_done;
   logic [15:0] cur_addr, cur_sum;
   assign cur_rd_en = sel_big ? rd_en_b   : rd_en_a;
   assign cur_done  = sel_big ? done_b    : done_a;
   assign cur_addr  = sel_big ? rd_addr_b : rd_addr_a;
   assign cur_sum   = sel_big ? sum_b     : sum_a;

   // Read monitor
   int          rd_cnt, low_cnt;
   logic [15:0] first_adr [3];
   always @(negedge clk) begin
      if (rst_n && cur_rd_en) begin
         if (rd_cnt < 3) first_adr[rd_cnt] <= cur_addr;
         if (cur_addr < 16'h8000) low_cnt <= low_cnt + 1;
         rd_cnt <= rd_cnt + 1;
      end
   end

   int total = 0, bad = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] expect_sum(input int last);
      logic [15:0] s;
      s = 16'(cfg_a & 14'h3EFF) + 16'(cfg_b & 14'h3F87);
      if (cfg_a[7]) begin
         for (int i = 0; i <= last; i++) s = s + 16'(mem_word(16'(i)));
      end else begin
         s = s + {uid[0][3:0], uid[1][3:0], uid[2][3:0], uid[3][3:0]};
      end
      return s;
   endfunction

   task automatic run_pass(input bit big, input bit poke, input logic [15:0] exp_sum, input string tag);
      int last, n, k;
      logic [15:0] held;
      last = big ? BIG_LAST : SMALL_LAST;
      n = 2 + (cfg_a[7] ? last + 1 : 4);
      @(negedge clk);
      sel_big = big;
      rd_cnt = 0;
      low_cnt = 0;
      if (big) start_b = 1'b1; else start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      start_b = 1'b0;
      k = 1;
      while (!cur_done && k < n + 10) begin
         if (poke && k == 5) begin
            if (big) start_b = 1'b1; else start_a = 1'b1;
         end else begin
            start_a = 1'b0;
            start_b = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      start_a = 1'b0;
      start_b = 1'b0;
      check(k == n + 2, {"R8 done latency ", tag}, k, n + 2);
      check(cur_sum == exp_sum, {"R3/R4/R5/R7 sum ", tag}, cur_sum, exp_sum);
      check(rd_cnt == n, {"R2 read count ", tag}, rd_cnt, n);
      check(first_adr[0] == 16'h8007 && first_adr[1] == 16'h8008, {"R2 config order ", tag},
            {first_adr[0], first_adr[1]}, 32'h8007_8008);
      if (cfg_a[7]) begin
         check(first_adr[2] == 16'h0000, {"R4 program start ", tag}, first_adr[2], 0);
         check(low_cnt == last + 1, {"R4 program reads ", tag}, low_cnt, last + 1);
      end else begin
         check(first_adr[2] == 16'h8000, {"R7 user ID start ", tag}, first_adr[2], 16'h8000);
         check(low_cnt == 0, {"R6/R7 no program reads ", tag}, low_cnt, 0);
      end
      held = cur_sum;
      @(negedge clk);
      check(!cur_done, {"R8 single pulse ", tag}, cur_done, 0);
      repeat (3) @(negedge clk);
      check(cur_sum == held, {"R8 hold ", tag}, cur_sum, held);
   endtask

   initial begin
      uid[0] = 14'h3FFF; uid[1] = 14'h3FFF; uid[2] = 14'h3FFF; uid[3] = 14'h3FFF;
      repeat (3) @(negedge clk);
      check(!done_a && !rd_en_a && sum_a == 0, "R1 reset small", {sum_a, 14'd0, done_a, rd_en_a}, 0);
      check(!done_b && !rd_en_b && sum_b == 0, "R1 reset big", {sum_b, 14'd0, done_b, rd_en_b}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10 blank images, also heavy 16-bit wrap (R3)
      mode = 0; cfg_a = 14'h3FFF; cfg_b = 14'h3FFF;
      run_pass(1'b0, 1'b0, 16'h6E86, "blank 4K R10");
      run_pass(1'b1, 1'b0, 16'h5E86, "blank 8K R10");

      // R4/R5 patterned program, masked config bits set outside masks
      mode = 1; cfg_a = 14'h3FFF; cfg_b = 14'h1234;
      run_pass(1'b0, 1'b0, expect_sum(SMALL_LAST), "pattern1 R4 R5");
      mode = 2; cfg_a = 14'h3D9F; cfg_b = 14'h0F7F;
      run_pass(1'b1, 1'b0, expect_sum(BIG_LAST), "pattern2 8K R4");

      // R9 start poked mid-pass
      mode = 1; cfg_a = 14'h3F80; cfg_b = 14'h2AAA;
      run_pass(1'b0, 1'b1, expect_sum(SMALL_LAST), "poke unprot R9");

      // R6/R7 protected: fixed nibble order case
      mode = 1; cfg_a = 14'h3F7F; cfg_b = 14'h3FFF;
      uid[0] = 14'h3FF1; uid[1] = 14'h0A52; uid[2] = 14'h1233; uid[3] = 14'h3C74;
      run_pass(1'b0, 1'b0, 16'(14'h3E7F) + 16'h3F87 + 16'h1234, "prot order R7");

      // R6/R7 sweep of nibble patterns and masked config values
      for (int s = 0; s < 16; s++) begin
         cfg_a = 14'(16'h3F7F ^ (s * 16'h0311)) & 14'h3F7F;
         cfg_b = 14'(s * 16'h0333 + 16'h0078);
         uid[0] = 14'(16'h3FF0 | s);
         uid[1] = 14'(16'h2AB0 | ((s * 3) & 15));
         uid[2] = 14'(16'h1550 | ((s * 7 + 1) & 15));
         uid[3] = 14'(16'h3C30 | (15 - s));
         run_pass(s[0], (s % 4) == 2, expect_sum(0), "prot sweep R6 R7 R9");
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R8 actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule